// File: doc/BRIEF.md
# Maskable Interrupt Gathering Controller

This block gathers the interrupt conditions of a dual-channel serial controller into one status word and one mask word, and drives a single active-low request line that a host sees as an open-drain interrupt. Each channel contributes three conditions: transmitter ready, receiver ready (or receive FIFO full), and a change in line-break state. Two more conditions are shared: the counter/timer reaching its terminal count, and a change seen on the monitored input pins.

The conditions are of two kinds. Level conditions (transmitter ready and receiver ready) are registered each cycle and follow their source. Event conditions (break change, counter done, input change) arrive as one-cycle pulses and are latched until their own clearing strobe arrives. Each condition has its own clearing strobe, issued by the surrounding logic when the host writes a transmit buffer, reads a receive buffer, issues a break-change reset, stops the counter or reads the input-change register. The status word always shows the raw conditions. The mask word decides which of them reach the request line. The counter, receiver-ready and transmitter-ready conditions can also be brought out as individual active-low lines, one per condition, which can be wired together off chip. A parameter chooses which of these lines are present.

Top module: `irq_gather`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the status word and the mask are all zero, `irq_n` is 1 and every bit of `route_n` is 1.
- R2: The status word uses this bit layout for channel c: bit 3c is transmitter ready, bit 3c+1 is receiver ready and bit 3c+2 is break change. With NUM_CHAN channels, bit 3*NUM_CHAN is counter done and bit 3*NUM_CHAN+1 is input change. A level bit takes, one cycle later, the value its `tx_ready`/`rx_ready` input had at the clock edge.
- R3: A `txbuf_wr[c]` or `rxbuf_rd[c]` strobe forces the matching level bit to 0 in the following cycle, whatever the level input is. After that the bit follows its input again.
- R4: An event bit is set one cycle after its pulse (`brk_chg[c]`, `ctr_done`, `pin_chg`). It stays set until its own clear strobe (`brk_rst[c]`, `ctr_stop`, `pin_rd`) and falls one cycle after that strobe. The strobes of other sources have no effect on it.
- R5: When an event pulse and the clear strobe of the same source arrive in the same cycle, the event bit is 1 in the following cycle.
- R6: The status word shows every condition whatever the mask holds.
- R7: `irq_n` is 0 exactly when at least one status bit and the matching mask bit are both 1. A `mask_we` replaces the whole mask with `mask_wdata`, and the new mask takes effect one cycle later. Clearing a mask bit therefore releases a request that only that source was holding.
- R8: `route_n` carries active-low copies of unmasked status bits: index 0 is counter done, index 1+c is receiver ready of channel c, and index 1+NUM_CHAN+c is transmitter ready of channel c. An index whose ROUTE_EN bit is 0 holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_ready | input | NUM_CHAN | Transmitter ready level, one bit per channel |
| rx_ready | input | NUM_CHAN | Receiver ready or FIFO full level, one bit per channel |
| brk_chg | input | NUM_CHAN | Break state change pulse, one bit per channel |
| ctr_done | input | 1 | Counter/timer terminal count pulse |
| pin_chg | input | 1 | Input pin change pulse |
| txbuf_wr | input | NUM_CHAN | Transmit buffer write strobe (clears transmitter ready) |
| rxbuf_rd | input | NUM_CHAN | Receive buffer read strobe (clears receiver ready) |
| brk_rst | input | NUM_CHAN | Break change reset command strobe |
| ctr_stop | input | 1 | Counter stop command strobe |
| pin_rd | input | 1 | Input change register read strobe |
| mask_we | input | 1 | Mask write strobe |
| mask_wdata | input | 3*NUM_CHAN+2 | New mask value |
| stat_q | output | 3*NUM_CHAN+2 | Raw status word |
| irq_n | output | 1 | Combined request, active low |
| route_n | output | 2*NUM_CHAN+1 | Individual active-low condition lines |

## Verification
Two actions can fall in the same cycle: an event pulse and the clear strobe of the same source, and a level input together with its buffer strobe. The bench drives both pairs on purpose in directed steps, and then at random during a long mixed run. A behavioural model in the bench computes the status word, the mask, the request and the routed lines. It treats a simultaneous pulse and clear as a set, and a strobe as overriding the level for one cycle. The bench compares the model with both instances at the falling edge of every clock. A second instance with all routed lines disabled shows that the parameter choice holds those lines high.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

   // status word layout
   function automatic int tx_bit(input int c);
      return 3 * c;
   endfunction

   function automatic int rx_bit(input int c);
      return 3 * c + 1;
   endfunction

   function automatic int brk_bit(input int c);
      return 3 * c + 2;
   endfunction

   function automatic int ctr_bit(input int n);
      return 3 * n;
   endfunction

   function automatic int pin_bit(input int n);
      return 3 * n + 1;
   endfunction

   // routed line layout
   function automatic int rx_route(input int c);
      return 1 + c;
   endfunction

   function automatic int tx_route(input int n, input int c);
      return 1 + n + c;
   endfunction

endpackage

// File: rtl/irq_level_bit.sv
module irq_level_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= cond & ~clr;
   end
endmodule

// File: rtl/irq_event_bit.sv
module irq_event_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   // set wins over a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= 1'b0;
      else if (set) q <= 1'b1;
      else if (clr) q <= 1'b0;
   end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] stat,
   output logic         req_n
);
   logic [W-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  mask_q <= '0;
      else if (we) mask_q <= wdata;
   end

   assign req_n = ~(|(stat & mask_q));
endmodule

// File: rtl/irq_route.sv
module irq_route
   import irq_gather_pkg::*;
#(
   parameter int          NUM_CHAN = 2,
   parameter logic [15:0] ROUTE_EN = '1,
   localparam int         W        = 3 * NUM_CHAN + 2,
   localparam int         RW       = 2 * NUM_CHAN + 1
) (
   input  logic [W-1:0]  stat,
   output logic [RW-1:0] route_n
);
   if (ROUTE_EN[0]) begin : g_ctr_on
      assign route_n[0] = ~stat[ctr_bit(NUM_CHAN)];
   end else begin : g_ctr_off
      assign route_n[0] = 1'b1;
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      if (ROUTE_EN[rx_route(c)]) begin : g_rx_on
         assign route_n[rx_route(c)] = ~stat[rx_bit(c)];
      end else begin : g_rx_off
         assign route_n[rx_route(c)] = 1'b1;
      end
      if (ROUTE_EN[tx_route(NUM_CHAN, c)]) begin : g_tx_on
         assign route_n[tx_route(NUM_CHAN, c)] = ~stat[tx_bit(c)];
      end else begin : g_tx_off
         assign route_n[tx_route(NUM_CHAN, c)] = 1'b1;
      end
   end
endmodule

// File: rtl/irq_gather.sv
module irq_gather
   import irq_gather_pkg::*;
#(
   parameter int          NUM_CHAN = 2,
   parameter logic [15:0] ROUTE_EN = '1,
   localparam int         W        = 3 * NUM_CHAN + 2,
   localparam int         RW       = 2 * NUM_CHAN + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_CHAN-1:0] tx_ready,
   input  logic [NUM_CHAN-1:0] rx_ready,
   input  logic [NUM_CHAN-1:0] brk_chg,
   input  logic                ctr_done,
   input  logic                pin_chg,
   input  logic [NUM_CHAN-1:0] txbuf_wr,
   input  logic [NUM_CHAN-1:0] rxbuf_rd,
   input  logic [NUM_CHAN-1:0] brk_rst,
   input  logic                ctr_stop,
   input  logic                pin_rd,
   input  logic                mask_we,
   input  logic [W-1:0]        mask_wdata,
   output logic [W-1:0]        stat_q,
   output logic                irq_n,
   output logic [RW-1:0]       route_n
);
   if (NUM_CHAN < 1 || NUM_CHAN > 4) begin : g_bad_chan
      $error("irq_gather: NUM_CHAN must lie in 1..4");
   end
   if (RW > 16) begin : g_bad_route
      $error("irq_gather: ROUTE_EN too narrow for NUM_CHAN");
   end

   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      irq_level_bit u_tx (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (tx_ready[c]),
         .clr   (txbuf_wr[c]),
         .q     (stat_q[tx_bit(c)])
      );
      irq_level_bit u_rx (
         .clk   (clk),
         .rst_n (rst_n),
         .cond  (rx_ready[c]),
         .clr   (rxbuf_rd[c]),
         .q     (stat_q[rx_bit(c)])
      );
      irq_event_bit u_brk (
         .clk   (clk),
         .rst_n (rst_n),
         .set   (brk_chg[c]),
         .clr   (brk_rst[c]),
         .q     (stat_q[brk_bit(c)])
      );
   end

   irq_event_bit u_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ctr_done),
      .clr   (ctr_stop),
      .q     (stat_q[ctr_bit(NUM_CHAN)])
   );

   irq_event_bit u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (pin_chg),
      .clr   (pin_rd),
      .q     (stat_q[pin_bit(NUM_CHAN)])
   );

   irq_mask_reg #(.W(W)) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (mask_we),
      .wdata (mask_wdata),
      .stat  (stat_q),
      .req_n (irq_n)
   );

   irq_route #(.NUM_CHAN(NUM_CHAN), .ROUTE_EN(ROUTE_EN)) u_route (
      .stat    (stat_q),
      .route_n (route_n)
   );
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk
   import irq_gather_pkg::*;
#(
   parameter int          NUM_CHAN = 2,
   parameter logic [15:0] ROUTE_EN = '1,
   localparam int         W        = 3 * NUM_CHAN + 2,
   localparam int         RW       = 2 * NUM_CHAN + 1
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_CHAN-1:0] tx_ready,
   input logic [NUM_CHAN-1:0] rx_ready,
   input logic [NUM_CHAN-1:0] brk_chg,
   input logic                ctr_done,
   input logic                pin_chg,
   input logic [NUM_CHAN-1:0] txbuf_wr,
   input logic [NUM_CHAN-1:0] rxbuf_rd,
   input logic [NUM_CHAN-1:0] brk_rst,
   input logic                ctr_stop,
   input logic                pin_rd,
   input logic                mask_we,
   input logic [W-1:0]        mask_wdata,
   input logic [W-1:0]        stat_q,
   input logic                irq_n,
   input logic [RW-1:0]       route_n
);
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      // R2
      tx_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !txbuf_wr[c] |=> stat_q[tx_bit(c)] == $past(tx_ready[c]));
      // R3
      rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rxbuf_rd[c] |=> !stat_q[rx_bit(c)]);
      // R4
      brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         stat_q[brk_bit(c)] && !brk_rst[c] |=> stat_q[brk_bit(c)]);
   end

   // R5
   ctr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_done && ctr_stop |=> stat_q[ctr_bit(NUM_CHAN)]);

   // R4
   pin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pin_rd && !pin_chg |=> !stat_q[pin_bit(NUM_CHAN)]);

   // R7
   mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we && mask_wdata == '0 |=> irq_n);

   // R7
   req_needs_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_n |-> stat_q != '0);

   // R8
   if (ROUTE_EN[0]) begin : g_ctr_route
      ctr_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ctr_done |=> !route_n[0]);
   end else begin : g_ctr_noroute
      ctr_noroute_chk: assert property (@(posedge clk) disable iff (!rst_n)
         route_n[0]);
   end
endmodule

bind irq_gather irq_gather_chk #(.NUM_CHAN(NUM_CHAN), .ROUTE_EN(ROUTE_EN)) u_chk (.*);

// File: tb/irq_gather_tb.sv
module irq_gather_tb;
   localparam int NC = 2;
   localparam int W  = 3 * NC + 2;
   localparam int RW = 2 * NC + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] tx_ready = '0, rx_ready = '0, brk_chg = '0;
   logic [NC-1:0] txbuf_wr = '0, rxbuf_rd = '0, brk_rst = '0;
   logic          ctr_done = 1'b0, pin_chg = 1'b0, ctr_stop = 1'b0, pin_rd = 1'b0;
   logic          mask_we = 1'b0;
   logic [W-1:0]  mask_wdata = '0;
   logic [W-1:0]  stat_q, stat_b;
   logic          irq_n, irq_b;
   logic [RW-1:0] route_n, route_b;

   always #10 clk = ~clk;

   irq_gather #(.NUM_CHAN(NC)) u_dut (
      .clk, .rst_n, .tx_ready, .rx_ready, .brk_chg, .ctr_done, .pin_chg,
      .txbuf_wr, .rxbuf_rd, .brk_rst, .ctr_stop, .pin_rd,
      .mask_we, .mask_wdata, .stat_q, .irq_n, .route_n
   );

   irq_gather #(.NUM_CHAN(NC), .ROUTE_EN(16'h0)) u_dut_noroute (
      .clk, .rst_n, .tx_ready, .rx_ready, .brk_chg, .ctr_done, .pin_chg,
      .txbuf_wr, .rxbuf_rd, .brk_rst, .ctr_stop, .pin_rd,
      .mask_we, .mask_wdata, .stat_q(stat_b), .irq_n(irq_b), .route_n(route_b)
   );

   // behavioural reference
   bit [W-1:0] m_stat, m_mask;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_stat = '0;
         m_mask = '0;
      end else begin
         bit [W-1:0] nx;
         nx = m_stat;
         for (int c = 0; c < NC; c++) begin
            nx[3*c]   = tx_ready[c] && !txbuf_wr[c];
            nx[3*c+1] = rx_ready[c] && !rxbuf_rd[c];
            nx[3*c+2] = brk_chg[c] || (m_stat[3*c+2] && !brk_rst[c]);
         end
         nx[3*NC]   = ctr_done || (m_stat[3*NC] && !ctr_stop);
         nx[3*NC+1] = pin_chg || (m_stat[3*NC+1] && !pin_rd);
         if (mask_we) m_mask = mask_wdata;
         m_stat = nx;
      end
   end

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic check_all(input string tag);
      bit [RW-1:0] er;
      bit          ei;
      er[0] = !m_stat[3*NC];
      for (int c = 0; c < NC; c++) begin
         er[1+c]    = !m_stat[3*c+1];
         er[1+NC+c] = !m_stat[3*c];
      end
      ei = !(|(m_stat & m_mask));
      n_cmp += 5;
      if (stat_q !== m_stat) begin
         n_bad++;
         $display("FAIL %s status: got %b expected %b", tag, stat_q, m_stat);
      end
      if (irq_n !== ei) begin
         n_bad++;
         $display("FAIL %s R7 irq_n: got %b expected %b", tag, irq_n, ei);
      end
      if (route_n !== er) begin
         n_bad++;
         $display("FAIL %s R8 route_n: got %b expected %b", tag, route_n, er);
      end
      if (stat_b !== m_stat || irq_b !== ei) begin
         n_bad++;
         $display("FAIL %s second instance: got %b/%b expected %b/%b", tag, stat_b, irq_b, m_stat, ei);
      end
      if (route_b !== '1) begin
         n_bad++;
         $display("FAIL %s R8 disabled routes: got %b expected %b", tag, route_b, {RW{1'b1}});
      end
   endtask

   // inputs set by caller before this; strobes are dropped after the check
   task automatic cyc(input string tag);
      @(negedge clk);
      check_all(tag);
      brk_chg = '0; txbuf_wr = '0; rxbuf_rd = '0; brk_rst = '0;
      ctr_done = 0; pin_chg = 0; ctr_stop = 0; pin_rd = 0; mask_we = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired: got hang expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      @(negedge clk);
      cyc("R1 in reset");
      cyc("R1 in reset");
      rst_n = 1'b1;
      cyc("R1 after reset");
      // R2 level following, mask still zero (R6 raw status)
      tx_ready = 2'b01; cyc("R2 tx0");
      rx_ready = 2'b10; cyc("R2 rx1");
      tx_ready = 2'b11; rx_ready = 2'b11; cyc("R2 all levels R6");
      tx_ready = 2'b00; cyc("R2 tx drop");
      // R3 strobes override the level
      rxbuf_rd = 2'b01; cyc("R3 rx0 strobe");
      cyc("R3 rx0 returns");
      tx_ready = 2'b10; txbuf_wr = 2'b10; cyc("R3 tx1 strobe with level");
      cyc("R3 tx1 returns");
      // R4 events latch
      brk_chg = 2'b01; cyc("R4 brk0 set");
      ctr_stop = 1; pin_rd = 1; brk_rst = 2'b10; cyc("R4 foreign clears");
      cyc("R4 brk0 held");
      ctr_done = 1; pin_chg = 1; brk_chg = 2'b10; cyc("R4 events set");
      brk_rst = 2'b01; cyc("R4 brk0 cleared");
      ctr_stop = 1; cyc("R4 ctr cleared");
      pin_rd = 1; brk_rst = 2'b10; cyc("R4 pin and brk1 cleared");
      // R5 set wins
      ctr_done = 1; ctr_stop = 1; pin_chg = 1; pin_rd = 1; cyc("R5 set and clear");
      brk_chg = 2'b11; brk_rst = 2'b11; cyc("R5 brk set and clear");
      cyc("R5 held");
      // R7 mask behaviour
      mask_wdata = 8'b0000_0100; mask_we = 1; cyc("R7 mask one event");
      cyc("R7 request asserted");
      mask_wdata = 8'b0000_0000; mask_we = 1; cyc("R7 mask cleared");
      cyc("R7 request released");
      mask_wdata = 8'b1111_1111; mask_we = 1; cyc("R7 mask all");
      ctr_stop = 1; pin_rd = 1; brk_rst = 2'b11; tx_ready = 0; rx_ready = 0; cyc("R7 clear all");
      cyc("R7 idle with full mask");
      // R8 routed lines and mixed traffic
      for (int i = 0; i < 3000; i++) begin
         tx_ready   = NC'($urandom);
         rx_ready   = NC'($urandom);
         brk_chg    = NC'($urandom) & NC'($urandom);
         brk_rst    = NC'($urandom) & NC'($urandom);
         txbuf_wr   = NC'($urandom) & NC'($urandom);
         rxbuf_rd   = NC'($urandom) & NC'($urandom);
         ctr_done   = ($urandom % 4) == 0;
         ctr_stop   = ($urandom % 4) == 0;
         pin_chg    = ($urandom % 4) == 0;
         pin_rd     = ($urandom % 4) == 0;
         mask_we    = ($urandom % 16) == 0;
         mask_wdata = W'($urandom);
         cyc("R8 R5 R7 mixed");
      end
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule